// File: doc/BRIEF.md
# Parallel Bus Target Interface

This block is the responding side of a synchronous 32-bit bus that shares its address and data wires. A transaction opens with an address phase. In that cycle the initiator lowers its frame strobe, puts the address on the shared lines and puts a command on the four command/byte-enable lines. The target decodes the address against a fixed window and checks that the command is a single-word memory read or write. If both match, it claims the transaction by lowering its device-select strobe. It then serves one 32-bit word from a small internal register array. The byte enables, which arrive on the command lines during the data phase, choose which bytes take part.

For a read, the cycle after the address phase is a turnaround cycle in which nobody drives the shared lines. The target drives data from the third cycle on. For a write, the initiator presents the data in the second cycle and no turnaround is needed. A wait-state count, sampled at the address phase, holds the target-ready strobe high for that many extra data cycles. The data phase ends on the first clock edge at which both ready strobes are low. The target then releases its strobes and returns to idle. Even parity over the driven data and the byte enables follows the data one cycle later. Line drive is modelled with output-enable signals rather than tri-state nets.

The state machine has four states. `ST_IDLE` goes to `ST_RD_TURN` on a claimed read and to `ST_WR_DATA` on a claimed write. `ST_RD_TURN` always goes to `ST_RD_DATA`. `ST_RD_DATA` and `ST_WR_DATA` return to `ST_IDLE` on completion. In every other case each state holds.

Top module: `ptgt_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `devsel_n` and `trdy_n` are high and `ad_oe` and `par_oe` are low.
- R2: An address phase is a cycle with `frame_n` low in which `frame_n` was high in the previous cycle. The target claims only when `cbe_n` is 4'b0110 (read) or 4'b0111 (write) and the address lies in [BASE_ADDR, BASE_ADDR + 4*NREG). In every other case `devsel_n` stays high and nothing is driven.
- R3: On a claimed read, the cycle after the address phase has `devsel_n` low and `ad_oe` low. Data is driven (`ad_oe` high) from the cycle after that.
- R4: On a write, byte lane k (bits 8k+7..8k) of the addressed register takes `ad_in` only when `cbe_n[k]` is 0, at the edge where `irdy_n` and `trdy_n` are both low. All other lanes keep their value.
- R5: During read data cycles, `ad_out` drives the register contents on lanes whose `cbe_n[k]` is 0 and drives zero on lanes whose `cbe_n[k]` is 1.
- R6: With W = `wait_cfg` sampled at the address phase (cycle 1), `trdy_n` first goes low in cycle 3+W for a read and in cycle 2+W for a write. It stays high in the earlier data cycles while `devsel_n` stays low.
- R7: In the cycle after an edge where `irdy_n` and `trdy_n` are both low during the data phase, `devsel_n` and `trdy_n` are high and `ad_oe` is low.
- R8: `par_oe` is high exactly in the cycle after one with `ad_oe` high. `par_out` then makes the count of ones over the previous cycle's `ad_out`, `cbe_n` and `par_out` even.
- R9: The register index is address bits [log2(NREG)+1:2]. Address bits [1:0] do not select the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Initiator frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables afterwards |
| ad_in | input | 32 | Shared address/data lines as seen by the target |
| wait_cfg | input | WAIT_W | Number of wait states to insert, sampled at the address phase |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Target drives the shared lines |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| par_out | output | 1 | Even parity for the previous driven cycle |
| par_oe | output | 1 | Target drives the parity line |

## Verification
On every cycle, the assertions check the signal ordering. Target-ready never appears without device-select. Data drive never starts unless device-select was already low the cycle before. The strobes are released right after completion. Parity enable trails data enable by exactly one cycle, with the parity value even.

Only the bench scenarios can show the data-level results. These are whether a write lands in the right register with the right lanes and whether the wait-state count sets the exact cycle of target-ready. They also cover whether unmatched addresses, foreign commands and a frame held low from an earlier phase are left unclaimed.

// File: rtl/ptgt_pkg.sv
package ptgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_TURN,
        ST_RD_DATA,
        ST_WR_DATA
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/ptgt_decode.sv
module ptgt_decode #(
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    parameter int          NREG      = 8,
    localparam int         IDX_W     = $clog2(NREG)
) (
    input  logic [31:0]      addr,
    input  logic [3:0]       cmd_n,
    output logic             claim_rd,
    output logic             claim_wr,
    output logic [IDX_W-1:0] idx
);
    import ptgt_pkg::*;

    localparam logic [32:0] LO = {1'b0, BASE_ADDR};
    localparam logic [32:0] HI = {1'b0, BASE_ADDR} + 33'(NREG * 4);

    logic in_win;

    always_comb begin
        in_win   = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
        claim_rd = in_win && (cmd_n == CMD_MEM_RD);
        claim_wr = in_win && (cmd_n == CMD_MEM_WR);
        idx      = addr[IDX_W+1:2];
    end
endmodule

// File: rtl/ptgt_regs.sv
module ptgt_regs #(
    parameter int  NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [3:0]       lane_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    logic [31:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            for (int k = 0; k < 4; k++)
                if (lane_en[k]) mem[idx][8*k +: 8] <= wdata[8*k +: 8];
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/ptgt_parity.sv
module ptgt_parity (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic        ad_oe,
    output logic        par_out,
    output logic        par_oe
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= ^{ad, cbe_n};
            par_oe  <= ad_oe;
        end
    end
endmodule

// File: rtl/ptgt_top.sv
module ptgt_top #(
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    parameter int          NREG      = 8,
    parameter int          WAIT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [3:0]        cbe_n,
    input  logic [31:0]       ad_in,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic [31:0]       ad_out,
    output logic              ad_oe,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              par_out,
    output logic              par_oe
);
    import ptgt_pkg::*;

    localparam int IDX_W = $clog2(NREG);

    tgt_state_e        state, nxt;
    logic              frame_q;
    logic [IDX_W-1:0]  idx_q, dec_idx;
    logic [WAIT_W-1:0] cnt_q;
    logic              claim_rd, claim_wr, addr_phase;
    logic              data_st, ready, done;
    logic [31:0]       rdata, lane_mask;

    ptgt_decode #(.BASE_ADDR(BASE_ADDR), .NREG(NREG)) u_dec (
        .addr(ad_in), .cmd_n(cbe_n),
        .claim_rd(claim_rd), .claim_wr(claim_wr), .idx(dec_idx)
    );

    ptgt_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(done && (state == ST_WR_DATA)), .lane_en(~cbe_n),
        .idx(idx_q), .wdata(ad_in), .rdata(rdata)
    );

    ptgt_parity u_par (
        .clk(clk), .rst_n(rst_n), .ad(ad_out), .cbe_n(cbe_n),
        .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe)
    );

    assign addr_phase = !frame_n && frame_q;
    assign data_st    = (state == ST_RD_DATA) || (state == ST_WR_DATA);
    assign ready      = data_st && (cnt_q == '0);
    assign done       = ready && !irdy_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Address-phase capture, wait counter, frame history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            frame_q <= frame_n;
            if (state == ST_IDLE && addr_phase) begin
                idx_q <= dec_idx;
                cnt_q <= wait_cfg;
            end else if (data_st && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (addr_phase && claim_rd)      nxt = ST_RD_TURN;
                else if (addr_phase && claim_wr) nxt = ST_WR_DATA;
            end
            ST_RD_TURN: nxt = ST_RD_DATA;
            ST_RD_DATA: if (done) nxt = ST_IDLE;
            ST_WR_DATA: if (done) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Byte-lane mask from active-low enables
    generate
        for (genvar k = 0; k < 4; k++) begin : g_lane
            assign lane_mask[8*k +: 8] = {8{~cbe_n[k]}};
        end
    endgenerate

    // Outputs
    always_comb begin
        devsel_n = (state == ST_IDLE);
        trdy_n   = !ready;
        ad_oe    = (state == ST_RD_DATA);
        ad_out   = ad_oe ? (rdata & lane_mask) : 32'h0;
    end

    // Assertions
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (devsel_n && trdy_n && !ad_oe && !par_oe));

    p_turn_before_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(!devsel_n));

    p_trdy_with_devsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    p_release_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !trdy_n) |=> (devsel_n && trdy_n && !ad_oe));

    p_par_trails_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe == $past(ad_oe));

    p_par_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> ((^{$past(ad_out), $past(cbe_n), par_out}) == 1'b0));
endmodule

// File: tb/sim_ptgt_top.sv
module sim_ptgt_top;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [3:0]  wait_cfg = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, par_out, par_oe;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mdl [NREG];

    always #5 clk = ~clk;

    ptgt_top #(.BASE_ADDR(BASE), .NREG(NREG), .WAIT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .wait_cfg(wait_cfg),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .par_out(par_out), .par_oe(par_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one bus cycle mid-period, then settle before sampling
    task automatic drv(input logic f, input logic ir, input logic [3:0] c, input logic [31:0] a);
        @(negedge clk);
        frame_n = f; irdy_n = ir; cbe_n = c; ad_in = a;
        #2;
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] be_n);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{~be_n[k]}};
        return m;
    endfunction

    task automatic t_reset;
        chk(devsel_n && trdy_n && !ad_oe && !par_oe, "R1 reset idle",
            {devsel_n, trdy_n, ad_oe, par_oe}, 32'hC);
    endtask

    task automatic t_read(input int idx, input logic [1:0] lo, input logic [3:0] be_n, input int w);
        logic [31:0] exp;
        logic        pexp;
        exp = mdl[idx] & bmask(be_n);
        wait_cfg = 4'(w);
        drv(1'b0, 1'b1, 4'b0110, BASE + 32'(4*idx) + 32'(lo));
        chk(devsel_n, "R2 no claim during address phase", {31'b0, devsel_n}, 1);
        drv(1'b1, 1'b0, be_n, 32'hFFFF_FFFF);
        chk(!devsel_n && !ad_oe, "R3 turnaround cycle", {devsel_n, ad_oe}, 0);
        for (int k = 0; k < w; k++) begin
            drv(1'b1, 1'b0, be_n, 32'h0);
            chk(trdy_n && !devsel_n, "R6 read wait state", {devsel_n, trdy_n}, 1);
        end
        drv(1'b1, 1'b0, be_n, 32'h0);
        chk(!trdy_n && ad_oe, "R6 read trdy cycle", {trdy_n, ad_oe}, 1);
        chk(ad_out == exp, "R5 R9 read data", ad_out, exp);
        pexp = ^{exp, be_n};
        drv(1'b1, 1'b1, 4'hF, 32'h0);
        chk(devsel_n && trdy_n && !ad_oe, "R7 release after read",
            {devsel_n, trdy_n, ad_oe}, 32'h6);
        chk(par_oe && par_out == pexp, "R8 parity after read",
            {par_oe, par_out}, {1'b1, pexp});
    endtask

    task automatic t_write(input int idx, input logic [3:0] be_n, input logic [31:0] d, input int w);
        wait_cfg = 4'(w);
        drv(1'b0, 1'b1, 4'b0111, BASE + 32'(4*idx));
        for (int k = 0; k < w; k++) begin
            drv(1'b1, 1'b0, be_n, d);
            chk(trdy_n && !devsel_n, "R6 write wait state", {devsel_n, trdy_n}, 1);
        end
        drv(1'b1, 1'b0, be_n, d);
        chk(!trdy_n && !devsel_n, "R6 write trdy cycle", {devsel_n, trdy_n}, 0);
        drv(1'b1, 1'b1, 4'hF, 32'h0);
        chk(devsel_n && trdy_n, "R7 release after write", {devsel_n, trdy_n}, 3);
        mdl[idx] = (mdl[idx] & ~bmask(be_n)) | (d & bmask(be_n));
        t_read(idx, 2'b00, 4'h0, 0);  // R4 read back
    endtask

    task automatic t_noclaim(input logic [31:0] a, input logic [3:0] cmd, input string why);
        drv(1'b0, 1'b1, cmd, a);
        for (int k = 0; k < 3; k++) begin
            drv(1'b1, 1'b0, 4'h0, 32'h5A5A_5A5A);
            chk(devsel_n && trdy_n && !ad_oe, why, {devsel_n, trdy_n, ad_oe}, 32'h6);
        end
        drv(1'b1, 1'b1, 4'hF, 32'h0);
    endtask

    task automatic t_held_frame;
        drv(1'b0, 1'b1, 4'b0110, 32'h0000_8000);
        drv(1'b0, 1'b1, 4'b0110, BASE);
        drv(1'b1, 1'b0, 4'h0, 32'h0);
        chk(devsel_n, "R2 held frame not an address phase", {31'b0, devsel_n}, 1);
        drv(1'b1, 1'b0, 4'h0, 32'h0);
        chk(devsel_n && !ad_oe, "R2 held frame no drive", {devsel_n, ad_oe}, 2);
        drv(1'b1, 1'b1, 4'hF, 32'h0);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        #2;
        t_reset();
        t_write(1, 4'h0, 32'hDEAD_BEEF, 0);
        t_write(2, 4'b1010, 32'h1122_3344, 2);            // R4 lanes 0 and 2 only
        t_write(7, 4'b0111, 32'hA5C3_0000, 1);            // R4 top lane only
        t_read(1, 2'b00, 4'b0110, 3);                     // R5 mask, R6 waits
        t_read(1, 2'b11, 4'h0, 1);                        // R9 low bits ignored
        t_read(2, 2'b00, 4'b1100, 0);
        t_noclaim(BASE + 32'(4*NREG), 4'b0110, "R2 above window");
        t_noclaim(BASE - 32'd4, 4'b0111, "R2 below window");
        t_noclaim(BASE + 32'd8, 4'b0010, "R2 foreign command");
        t_held_frame();
        t_read(2, 2'b00, 4'h0, 0);                        // R4 untouched by no-claim writes
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule